// File: doc/BRIEF.md
# Line Activity Receiver Error Monitor

This block sits beside a serial deserializer. It decides what a burst of line transitions means once a message has ended or bit sync has been lost. It keeps its own line-activity flag. Every line transition re-arms the flag, and the flag drops after a run of quiet microseconds. When an end of message or a loss of sync opens a watch window, the block compares two events. If the line goes quiet before a frame time has passed, the block sends a one-cycle reset pulse to the deserializer and flags nothing. If the transitions keep the line active for the whole frame window, the block posts a sticky late-mid-bit-transition error.

A start-bit strobe from the deserializer means the noise looked like a real frame. The block then enters frame mode. A loss of sync in frame mode posts the error at once.

All timing is counted in microsecond ticks divided down from the system clock, so the clock rate is a parameter. Software clears the error flag with a one-cycle clear strobe.

Top module: `line_activity_monitor`

## Requirements
- R1: After reset, line_active, window_open, rx_reset and late_err are all 0.
- R2: line_active is 1 in the cycle after any line_edge. With no further edge it falls to 0 between (ACT_US-1)*CLK_PER_US+1 and ACT_US*CLK_PER_US cycles after the edge is registered.
- R3: When no window is open, a msg_end or sync_lost strobe without start_seen opens the watch window. window_open reads 1 in the next cycle.
- R4: While the window is open and line_active is 0, the block issues a single rx_reset pulse and closes the window. late_err is unchanged.
- R5: If line_active stays 1 for FRAME_US microsecond ticks after the window opens, late_err becomes 1 and the window closes, with no rx_reset. The flag is visible between (FRAME_US-1)*CLK_PER_US+2 and FRAME_US*CLK_PER_US+1 cycles after the opening strobe.
- R6: A sync_lost or msg_end strobe while the window is open restarts the full FRAME_US window.
- R7: A start_seen strobe without sync_lost enters frame mode, and window_open reads 0. A sync_lost in frame mode sets late_err in the next cycle, with no rx_reset.
- R8: start_seen and sync_lost in the same cycle set late_err in the next cycle, whatever the state.
- R9: late_err holds at 1 until err_clr. When err_clr and a new error fall in the same cycle, late_err ends at 1.
- R10: rx_reset is never high for two consecutive cycles.
- R11: In frame mode, a msg_end opens the watch window. If line activity dies in frame mode, the block returns to idle with no reset and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_edge | input | 1 | One-cycle strobe per line transition |
| sync_lost | input | 1 | One-cycle loss-of-sync strobe from the deserializer |
| start_seen | input | 1 | One-cycle start-bit strobe from the deserializer |
| msg_end | input | 1 | One-cycle end-of-message (fill bits seen) strobe |
| err_clr | input | 1 | One-cycle clear of the sticky error |
| line_active | output | 1 | Line-activity flag |
| window_open | output | 1 | Watch window after end of message or sync loss is open |
| rx_reset | output | 1 | One-cycle silent reset to the deserializer |
| late_err | output | 1 | Sticky late-mid-bit-transition error |

## Verification
Two events can land in the same cycle: a start-bit strobe and a loss-of-sync strobe. Only the merged reading counts, which is a frame that began and then lost sync. The bench drives both strobes on one clock, once from idle and once together with an err_clr while the flag is already set. It expects late_err one cycle later with no reset pulse, and expects the set to win over the clear.

// File: rtl/lam_pkg.sv
// Package: shared state type for the line activity monitor.
// Assumes: nothing beyond a two-bit state encoding.
package lam_pkg;
    typedef enum logic [1:0] {
        WIN_IDLE  = 2'd0,
        WIN_WATCH = 2'd1,
        WIN_FRAME = 2'd2
    } win_state_e;
endpackage

// File: rtl/lam_tick_gen.sv
// Module: lam_tick_gen
// Divides the system clock into a one-cycle pulse once per microsecond.
// Assumes: CLK_PER_US clock cycles make one microsecond; free running.
module lam_tick_gen #(
    parameter int CLK_PER_US = 125
) (
    input  logic clk,
    input  logic rst_n,
    output logic us_tick
);
    localparam int DW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [DW-1:0] LAST = DW'(CLK_PER_US - 1);

    logic [DW-1:0] div_q;

    // Wrap-around divider counting clock cycles within one microsecond.
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= '0;
        else if (div_q == LAST)
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end

    assign us_tick = (div_q == LAST);
endmodule

// File: rtl/lam_activity_timer.sv
// Module: lam_activity_timer
// Holds the line-activity flag: each line edge reloads a countdown of
// ACT_US microsecond ticks, and the flag is high while it is non-zero.
// Assumes: line_edge and us_tick are single-cycle strobes; an edge wins
// over a tick in the same cycle.
module lam_activity_timer #(
    parameter int ACT_US = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic line_edge,
    output logic line_active
);
    localparam int AW = $clog2(ACT_US + 1);
    localparam logic [AW-1:0] LOAD = AW'(ACT_US);

    logic [AW-1:0] quiet_q;

    // Reload on a transition, count quiet microseconds down otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            quiet_q <= '0;
        else if (line_edge)
            quiet_q <= LOAD;
        else if (us_tick && (quiet_q != '0))
            quiet_q <= quiet_q - 1'b1;
    end

    assign line_active = (quiet_q != '0);
endmodule

// File: rtl/lam_window_ctrl.sv
// Module: lam_window_ctrl
// Decides between a silent receiver reset and a posted error. It opens a
// FRAME_US microsecond window after end of message or sync loss and tracks
// frame mode after a start bit. It also owns the sticky error flag.
// Assumes: strobes are single-cycle; line_active comes from the activity
// timer; a new error wins over a software clear in the same cycle.
module lam_window_ctrl
    import lam_pkg::*;
#(
    parameter int FRAME_US = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic line_active,
    input  logic sync_lost,
    input  logic start_seen,
    input  logic msg_end,
    input  logic err_clr,
    output logic window_open,
    output logic rx_reset,
    output logic late_err
);
    localparam int FW = $clog2(FRAME_US + 1);
    localparam logic [FW-1:0] WIN_LOAD = FW'(FRAME_US);
    localparam logic [FW-1:0] WIN_ONE  = FW'(1);

    win_state_e    state_q, state_d;
    logic [FW-1:0] win_q, win_d;
    logic          rst_d, post_err, restart, start_loss;

    assign restart    = sync_lost | msg_end;
    assign start_loss = start_seen & sync_lost;

    // Next-state decision for window, frame mode and the two outcomes.
    always_comb begin
        state_d  = state_q;
        win_d    = win_q;
        rst_d    = 1'b0;
        post_err = 1'b0;
        unique case (state_q)
            WIN_IDLE: begin
                if (start_loss) begin
                    post_err = 1'b1;
                end else if (start_seen) begin
                    state_d = WIN_FRAME;
                end else if (restart) begin
                    state_d = WIN_WATCH;
                    win_d   = WIN_LOAD;
                end
            end
            WIN_WATCH: begin
                if (start_loss) begin
                    post_err = 1'b1;
                    state_d  = WIN_IDLE;
                end else if (start_seen) begin
                    state_d = WIN_FRAME;
                end else if (restart) begin
                    win_d = WIN_LOAD;
                end else if (!line_active) begin
                    rst_d   = 1'b1;
                    state_d = WIN_IDLE;
                end else if (us_tick) begin
                    if (win_q <= WIN_ONE) begin
                        post_err = 1'b1;
                        state_d  = WIN_IDLE;
                    end else begin
                        win_d = win_q - 1'b1;
                    end
                end
            end
            WIN_FRAME: begin
                if (sync_lost) begin
                    post_err = 1'b1;
                    state_d  = WIN_IDLE;
                end else if (msg_end) begin
                    state_d = WIN_WATCH;
                    win_d   = WIN_LOAD;
                end else if (!line_active) begin
                    state_d = WIN_IDLE;
                end
            end
            default: state_d = WIN_IDLE;
        endcase
    end

    // State, window count and the registered reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= WIN_IDLE;
            win_q    <= '0;
            rx_reset <= 1'b0;
        end else begin
            state_q  <= state_d;
            win_q    <= win_d;
            rx_reset <= rst_d;
        end
    end

    // Sticky error: a new error outranks a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            late_err <= 1'b0;
        else if (post_err)
            late_err <= 1'b1;
        else if (err_clr)
            late_err <= 1'b0;
    end

    assign window_open = (state_q == WIN_WATCH);
endmodule

// File: rtl/line_activity_monitor.sv
// Module: line_activity_monitor (top)
// Receiver-side monitor that tells post-message noise from a real error.
// Assumes: all inputs are synchronous single-cycle strobes in the clk
// domain; CLK_PER_US clock cycles make one microsecond.
module line_activity_monitor #(
    parameter int CLK_PER_US = 125,
    parameter int ACT_US     = 2,
    parameter int FRAME_US   = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_edge,
    input  logic sync_lost,
    input  logic start_seen,
    input  logic msg_end,
    input  logic err_clr,
    output logic line_active,
    output logic window_open,
    output logic rx_reset,
    output logic late_err
);
    logic us_tick;

    lam_tick_gen #(.CLK_PER_US(CLK_PER_US)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .us_tick (us_tick)
    );

    lam_activity_timer #(.ACT_US(ACT_US)) u_act (
        .clk         (clk),
        .rst_n       (rst_n),
        .us_tick     (us_tick),
        .line_edge   (line_edge),
        .line_active (line_active)
    );

    lam_window_ctrl #(.FRAME_US(FRAME_US)) u_win (
        .clk         (clk),
        .rst_n       (rst_n),
        .us_tick     (us_tick),
        .line_active (line_active),
        .sync_lost   (sync_lost),
        .start_seen  (start_seen),
        .msg_end     (msg_end),
        .err_clr     (err_clr),
        .window_open (window_open),
        .rx_reset    (rx_reset),
        .late_err    (late_err)
    );
endmodule

// File: rtl/lam_checker.sv
// Module: lam_checker
// Port-level properties of the line activity monitor, bound to the top.
// Assumes: synchronous active-low reset; all properties off during reset.
module lam_checker (
    input logic clk,
    input logic rst_n,
    input logic line_edge,
    input logic sync_lost,
    input logic start_seen,
    input logic msg_end,
    input logic err_clr,
    input logic line_active,
    input logic window_open,
    input logic rx_reset,
    input logic late_err
);
    // R10
    single_cycle_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_reset |=> !rx_reset);

    // R2
    edge_arms_activity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_edge |=> line_active);

    // R3
    eom_opens_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_end && !sync_lost && !start_seen) |=> window_open);

    // R4
    reset_closes_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_reset |-> !window_open);

    // R5
    error_without_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(late_err) |-> !rx_reset);

    // R8
    start_loss_posts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_seen && sync_lost) |=> late_err);

    // R9
    sticky_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (late_err && !err_clr) |=> late_err);
endmodule

bind line_activity_monitor lam_checker u_lam_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_edge   (line_edge),
    .sync_lost   (sync_lost),
    .start_seen  (start_seen),
    .msg_end     (msg_end),
    .err_clr     (err_clr),
    .line_active (line_active),
    .window_open (window_open),
    .rx_reset    (rx_reset),
    .late_err    (late_err)
);

// File: tb/tb_line_activity_monitor.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_line_activity_monitor;
    localparam int P  = 4;
    localparam int AU = 2;
    localparam int FU = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_edge = 1'b0, sync_lost = 1'b0, start_seen = 1'b0;
    logic msg_end = 1'b0, err_clr = 1'b0;
    logic line_active, window_open, rx_reset, late_err;

    int checks = 0;
    int fails = 0;
    int rst_count = 0;
    int rst_wide = 0;
    logic rst_prev = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    line_activity_monitor #(.CLK_PER_US(P), .ACT_US(AU), .FRAME_US(FU)) dut (
        .clk(clk), .rst_n(rst_n), .line_edge(line_edge), .sync_lost(sync_lost),
        .start_seen(start_seen), .msg_end(msg_end), .err_clr(err_clr),
        .line_active(line_active), .window_open(window_open),
        .rx_reset(rx_reset), .late_err(late_err)
    );

    // Count reset pulses and any pulse longer than one cycle.
    always @(negedge clk) begin
        if (rx_reset) rst_count++;
        if (rx_reset && rst_prev) rst_wide++;
        rst_prev = rx_reset;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cycle: wait for the falling edge, then drive this cycle's strobes.
    task automatic cyc(input logic e, input logic l, input logic s,
                       input logic m, input logic c);
        @(negedge clk);
        line_edge = e; sync_lost = l; start_seen = s; msg_end = m; err_clr = c;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
    endtask

    task automatic clear_err();
        cyc(0, 0, 0, 0, 1);
        idle(2);
    endtask

    task automatic t_reset();
        check(line_active == 1'b0, "R1 line_active", line_active, 0);
        check(window_open == 1'b0, "R1 window_open", window_open, 0);
        check(rx_reset == 1'b0, "R1 rx_reset", rx_reset, 0);
        check(late_err == 1'b0, "R1 late_err", late_err, 0);
    endtask

    task automatic t_activity();
        int k = 0;
        cyc(1, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        check(line_active == 1'b1, "R2 arm", line_active, 1);
        if (line_active) k++;
        for (int i = 2; i < 16; i++) begin
            cyc(0, 0, 0, 0, 0);
            if (line_active) k++;
        end
        check(k >= (AU - 1) * P + 1 && k <= AU * P, "R2 timeout", k, AU * P);
        idle(4);
    endtask

    task automatic t_quiet_noise();
        int r0 = rst_count;
        cyc(1, 0, 0, 1, 0);
        for (int i = 1; i <= 60; i++) begin
            cyc((i % 3 == 0) && (i <= 15), 0, 0, 0, 0);
            if (i == 1) check(window_open == 1'b1, "R3 window opens", window_open, 1);
        end
        check(rst_count - r0 == 1, "R4 silent reset", rst_count - r0, 1);
        check(late_err == 1'b0, "R4 no error", late_err, 0);
        check(window_open == 1'b0, "R4 window closed", window_open, 0);
    endtask

    task automatic t_persist();
        int r0 = rst_count;
        int at = -1;
        cyc(1, 1, 0, 0, 0);
        for (int i = 1; i <= 60; i++) begin
            cyc(i % 3 == 0, 0, 0, 0, 0);
            if (late_err && at < 0) at = i;
        end
        check(at >= (FU - 1) * P + 2 && at <= FU * P + 1, "R5 error time", at, FU * P);
        check(rst_count == r0, "R5 no reset", rst_count - r0, 0);
        check(window_open == 1'b0, "R5 window closed", window_open, 0);
        idle(10);
    endtask

    task automatic t_sticky();
        idle(5);
        check(late_err == 1'b1, "R9 holds", late_err, 1);
        cyc(0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 0);
        check(late_err == 1'b0, "R9 cleared", late_err, 0);
        idle(3);
    endtask

    task automatic t_restart();
        int at = -1;
        int mid = 0;
        cyc(1, 1, 0, 0, 0);
        for (int i = 1; i <= 90; i++) begin
            cyc(i % 3 == 0, i == 30, 0, 0, 0);
            if (i == 60) mid = late_err;
            if (late_err && at < 0) at = i;
        end
        check(mid == 0, "R6 no early error", mid, 0);
        check(at >= 30 + (FU - 1) * P + 2 && at <= 30 + FU * P + 1,
              "R6 restarted window", at, 30 + FU * P);
        idle(10);
        clear_err();
    endtask

    task automatic t_frame();
        int r0 = rst_count;
        cyc(1, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 0);
        check(window_open == 1'b0, "R7 frame mode", window_open, 0);
        for (int i = 2; i <= 10; i++) cyc(i % 3 == 0, i == 10, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        check(late_err == 1'b1, "R7 loss in frame", late_err, 1);
        idle(12);
        check(rst_count == r0, "R7 no reset", rst_count - r0, 0);
        clear_err();
    endtask

    task automatic t_same_cycle();
        cyc(0, 1, 1, 0, 0);
        cyc(0, 0, 0, 0, 0);
        check(late_err == 1'b1, "R8 start and loss", late_err, 1);
        check(window_open == 1'b0, "R8 no window", window_open, 0);
        cyc(0, 1, 1, 0, 1);
        cyc(0, 0, 0, 0, 0);
        check(late_err == 1'b1, "R9 set beats clear", late_err, 1);
        clear_err();
    endtask

    task automatic t_frame_quiet();
        int r0 = rst_count;
        cyc(1, 0, 1, 0, 0);
        idle(20);
        check(late_err == 1'b0, "R11 quiet frame no error", late_err, 0);
        check(rst_count == r0, "R11 quiet frame no reset", rst_count - r0, 0);
        cyc(1, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 0);
        cyc(1, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 0);
        check(window_open == 1'b1, "R11 eom in frame", window_open, 1);
        idle(20);
        check(rst_count - r0 == 1, "R11 then silent reset", rst_count - r0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_activity();
        t_quiet_noise();
        t_persist();
        t_sticky();
        t_restart();
        t_frame();
        t_same_cycle();
        t_frame_quiet();
        check(rst_wide == 0, "R10 single-cycle reset", rst_wide, 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule